// File: doc/BRIEF.md
# Four-Slot Transmit Descriptor Engine

This block drives frame transmission from four descriptor slots. Each slot holds a buffer base address and a control/status word. Software programs the slot the engine expects next: first the address, then the control word, which carries the frame length and an early-start threshold. Writing the control word launches a fetch. The engine reads the frame one byte at a time through a request/grant memory port into an internal FIFO. It streams the frame onto a byte output and then appends four placeholder check bytes.

When a frame finishes, the slot's word reports ownership and the outcome, an interrupt flag is raised, and the engine moves on to the next slot in fixed circular order. If the FIFO runs dry in the middle of a frame, the frame is cut short and reported as failed. Interrupt flags are cleared by writing ones to them. All registers are read through a port with one cycle of latency.

Top module: `txdesc_engine`

## Requirements
- R1: After reset every control word reads 0x00002000 (only the host-owned bit 13 set), every address reads 0, the interrupt register (offset 0x3C) reads 0, and tx_valid, tx_last, tx_abort, mem_req and irq are low.
- R2: A control write to the current slot while the engine is idle keeps bits 12:0 (length) and 21:16 (threshold) and clears all other bits, including bit 13. It starts a fetch beginning at the slot's address. Control words sit at 0x10+4*slot and addresses at 0x20+4*slot.
- R3: A write to the address or control word of any slot other than the current one, or any such write while a frame is in progress, has no effect.
- R4: Payload byte i is the memory byte at address base+i, emitted in order with tx_valid high. mem_rdata is taken from the cycle after a cycle in which mem_req and mem_gnt are both high.
- R5: Short frames are not padded. After the payload come exactly four zero bytes, so a frame on the output is length+4 bytes long, and tx_last marks the final byte only.
- R6: Output starts once the FIFO holds at least one byte and either holds at least threshold*32 bytes, is full, or holds the whole payload. A threshold larger than the FIFO therefore never stalls a frame.
- R7: Bit 13 of the active slot returns to 1 as soon as the whole payload has been written into the FIFO, before the frame leaves the output.
- R8: On normal completion, bit 15 of the slot and interrupt bit 2 (transmit OK) are set on the same edge that raises tx_last, and irq goes high.
- R9: If the FIFO is empty while payload bytes are still due after output has begun, the engine pulses tx_abort instead of sending further bytes. It sets bits 13, 14 and 30 of the slot, leaves bit 15 clear, and sets interrupt bit 3 (transmit error).
- R10: After each completion or abort, the current slot advances by one, wrapping from 3 back to 0.
- R11: Writing the interrupt register clears bit 2 and/or bit 3 where the written data has a 1. Zeros leave the bits unchanged, and a set on the same edge wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 8 | Register read byte offset |
| reg_rdata | output | 32 | Register read data, one cycle after reg_raddr |
| mem_req | output | 1 | Byte fetch request |
| mem_addr | output | ADDR_W | Byte fetch address |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 8 | Fetched byte, valid the cycle after a grant |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a completed frame |
| tx_abort | output | 1 | One-cycle pulse when a frame is cut off by underrun |
| irq | output | 1 | OR of the two interrupt flags |

## Verification
The checker depends on three conditions. Every programmed length is non-zero. Memory returns data exactly one cycle after a grant. The grant input is free to stall for any number of cycles. The bench keeps within these conditions by writing only non-zero lengths and by modelling memory as a registered lookup of the address. Its grant patterns are always-on, alternating, and cut off after a fixed number of grants. The cut-off pattern is what deliberately provokes the underrun path.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FCS} eng_state_t;

  // register byte offsets; slot k sits at base + 4*k
  localparam int OFF_STAT = 8'h10;
  localparam int OFF_ADDR = 8'h20;
  localparam int OFF_IRQ  = 8'h3C;

  // control/status word layout
  localparam int LEN_MSB = 12;
  localparam int B_OWN   = 13;
  localparam int B_UNDR  = 14;
  localparam int B_OK    = 15;
  localparam int THR_LSB = 16;
  localparam int THR_MSB = 21;
  localparam int B_ABRT  = 30;

  localparam logic [31:0] STAT_RESET = 32'h0000_2000;
  localparam logic [31:0] STAT_WMASK = 32'h003F_1FFF;

  // interrupt register bits
  localparam int IRQ_OK  = 2;
  localparam int IRQ_ERR = 3;

  localparam int FCS_BYTES = 4;
endpackage

// File: rtl/txdesc_fifo.sv
module txdesc_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       rd_en,
  output logic [DW-1:0]              rd_data,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  // storage and registered read: no reset, so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q] <= wr_data;
    if (rd_en) rd_data <= mem[rptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en) wptr_q <= wptr_q + 1'b1;
      if (rd_en) rptr_q <= rptr_q + 1'b1;
      cnt_q <= cnt_q + CW'(wr_en) - CW'(rd_en);
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/txdesc_fetch.sv
module txdesc_fetch #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 13,
  parameter int CNT_W  = 7,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  logic [CNT_W-1:0]  fifo_cnt,
  input  logic              mem_gnt,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              wr_valid,
  output logic              done
);
  logic              active_q, inflight_q;
  logic [LEN_W-1:0]  req_cnt_q, wr_cnt_q, len_q;
  logic [ADDR_W-1:0] base_q;
  logic              room, grant;

  // reserve a FIFO entry for the byte already on its way back
  assign room     = ({1'b0, fifo_cnt} + (CNT_W+1)'(inflight_q)) < (CNT_W+1)'(DEPTH);
  assign mem_req  = active_q && (req_cnt_q != len_q) && room;
  assign mem_addr = base_q + ADDR_W'(req_cnt_q);
  assign grant    = mem_req && mem_gnt;
  assign wr_valid = inflight_q;
  assign done     = active_q && (wr_cnt_q == len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= 1'b0;
      inflight_q <= 1'b0;
      req_cnt_q  <= '0;
      wr_cnt_q   <= '0;
      len_q      <= '0;
      base_q     <= '0;
    end else if (start) begin
      active_q   <= 1'b1;
      inflight_q <= 1'b0;
      req_cnt_q  <= '0;
      wr_cnt_q   <= '0;
      len_q      <= len;
      base_q     <= base;
    end else if (stop) begin
      active_q   <= 1'b0;
      inflight_q <= 1'b0;
    end else begin
      inflight_q <= grant;
      if (grant)      req_cnt_q <= req_cnt_q + 1'b1;
      if (inflight_q) wr_cnt_q  <= wr_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/txdesc_engine.sv
module txdesc_engine
  import txdesc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int FIFO_DEPTH = 64,
  parameter int N_SLOTS    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [7:0]        reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic [7:0]        reg_raddr,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              tx_abort,
  output logic              irq
);
  localparam int CNT_W  = $clog2(FIFO_DEPTH+1);
  localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
  localparam int LEN_W  = LEN_MSB + 1;
  localparam int THR_W  = THR_MSB - THR_LSB + 1;
  localparam int FCS_W  = $clog2(FCS_BYTES);

  eng_state_t                  state_q;
  logic [SLOT_W-1:0]           cur_q;
  logic [N_SLOTS-1:0][31:0]    stat_v, addr_v;
  logic [N_SLOTS-1:0]          hit_stat, hit_addr;
  logic                        hit_irq, idle, start;
  logic                        sending_q, pay_vld_q, fcs_vld_q, last_q, abort_q;
  logic                        irq_ok_q, irq_err_q;
  logic [LEN_W-1:0]            pop_cnt_q, len_cur;
  logic [THR_W-1:0]            thr_cur;
  logic [FCS_W-1:0]            fcs_cnt_q;
  logic [15:0]                 thr_bytes, fill16;
  logic [CNT_W-1:0]            fifo_cnt;
  logic [7:0]                  fifo_q;
  logic                        fetch_wr, fetch_done;
  logic                        go, remaining, pop, underrun, pay_end, fcs_end, finish;
  logic [31:0]                 rd_mux, rdata_q;

  // ---------------- register write decode ----------------
  generate
    for (genvar i = 0; i < N_SLOTS; i++) begin : g_dec
      assign hit_stat[i] = reg_wr && (reg_waddr == 8'(OFF_STAT + 4*i));
      assign hit_addr[i] = reg_wr && (reg_waddr == 8'(OFF_ADDR + 4*i));
    end
  endgenerate
  assign hit_irq = reg_wr && (reg_waddr == 8'(OFF_IRQ));
  assign idle    = (state_q == ST_IDLE);
  assign start   = idle && hit_stat[cur_q];

  // ---------------- frame control ----------------
  assign len_cur   = stat_v[cur_q][LEN_MSB:0];
  assign thr_cur   = stat_v[cur_q][THR_MSB:THR_LSB];
  assign thr_bytes = 16'(thr_cur) << 5;
  assign fill16    = 16'(fifo_cnt);

  assign go        = (state_q == ST_RUN) && !sending_q && (fifo_cnt != '0) &&
                     ((fill16 >= thr_bytes) || (fill16 >= 16'(FIFO_DEPTH)) || fetch_done);
  assign remaining = (pop_cnt_q != len_cur);
  assign pop       = (state_q == ST_RUN) && sending_q && remaining && (fifo_cnt != '0);
  assign underrun  = (state_q == ST_RUN) && sending_q && remaining && (fifo_cnt == '0);
  assign pay_end   = pop && (LEN_W'(pop_cnt_q + 1'b1) == len_cur);
  assign fcs_end   = (state_q == ST_FCS) && (fcs_cnt_q == FCS_W'(FCS_BYTES-1));
  assign finish    = fcs_end || underrun;

  txdesc_fetch #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)
  ) u_fetch (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .stop     (finish),
    .base     (addr_v[cur_q][ADDR_W-1:0]),
    .len      (reg_wdata[LEN_MSB:0]),
    .fifo_cnt (fifo_cnt),
    .mem_gnt  (mem_gnt),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .wr_valid (fetch_wr),
    .done     (fetch_done)
  );

  txdesc_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .flush   (finish),
    .wr_en   (fetch_wr),
    .wr_data (mem_rdata),
    .rd_en   (pop),
    .rd_data (fifo_q),
    .count   (fifo_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cur_q     <= '0;
      sending_q <= 1'b0;
      pop_cnt_q <= '0;
      fcs_cnt_q <= '0;
      pay_vld_q <= 1'b0;
      fcs_vld_q <= 1'b0;
      last_q    <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      pay_vld_q <= pop;
      fcs_vld_q <= (state_q == ST_FCS);
      last_q    <= fcs_end;
      abort_q   <= underrun;
      if (pop) pop_cnt_q <= pop_cnt_q + 1'b1;
      if (go)  sending_q <= 1'b1;
      case (state_q)
        ST_IDLE: if (start) begin
          state_q   <= ST_RUN;
          sending_q <= 1'b0;
          pop_cnt_q <= '0;
        end
        ST_RUN: begin
          if (underrun)     state_q <= ST_IDLE;
          else if (pay_end) begin
            state_q   <= ST_FCS;
            fcs_cnt_q <= '0;
          end
        end
        ST_FCS: begin
          fcs_cnt_q <= fcs_cnt_q + 1'b1;
          if (fcs_end) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (finish)
        cur_q <= (cur_q == SLOT_W'(N_SLOTS-1)) ? '0 : cur_q + 1'b1;
    end
  end

  // ---------------- per-slot registers ----------------
  generate
    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
      logic [31:0] stat_r, addr_r;
      logic        sel;
      assign sel       = (cur_q == SLOT_W'(i));
      assign stat_v[i] = stat_r;
      assign addr_v[i] = addr_r;

      always_ff @(posedge clk) begin
        if (rst) begin
          stat_r <= STAT_RESET;
          addr_r <= '0;
        end else begin
          if (sel && idle && hit_stat[i]) begin
            stat_r <= reg_wdata & STAT_WMASK;
          end else if (sel) begin
            if ((state_q == ST_RUN) && fetch_done) stat_r[B_OWN] <= 1'b1;
            if (fcs_end) stat_r[B_OK] <= 1'b1;
            if (underrun) begin
              stat_r[B_OWN]  <= 1'b1;
              stat_r[B_UNDR] <= 1'b1;
              stat_r[B_ABRT] <= 1'b1;
            end
          end
          if (sel && idle && hit_addr[i]) addr_r <= reg_wdata;
        end
      end
    end
  endgenerate

  // ---------------- interrupt flags ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_ok_q  <= 1'b0;
      irq_err_q <= 1'b0;
    end else begin
      if (fcs_end)                             irq_ok_q  <= 1'b1;
      else if (hit_irq && reg_wdata[IRQ_OK])   irq_ok_q  <= 1'b0;
      if (underrun)                            irq_err_q <= 1'b1;
      else if (hit_irq && reg_wdata[IRQ_ERR])  irq_err_q <= 1'b0;
    end
  end

  // ---------------- read port ----------------
  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < N_SLOTS; k++) begin
      if (reg_raddr == 8'(OFF_STAT + 4*k)) rd_mux = stat_v[k];
      if (reg_raddr == 8'(OFF_ADDR + 4*k)) rd_mux = addr_v[k];
    end
    if (reg_raddr == 8'(OFF_IRQ)) begin
      rd_mux[IRQ_OK]  = irq_ok_q;
      rd_mux[IRQ_ERR] = irq_err_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;
  assign tx_valid  = pay_vld_q || fcs_vld_q;
  assign tx_data   = pay_vld_q ? fifo_q : 8'h00;
  assign tx_last   = last_q;
  assign tx_abort  = abort_q;
  assign irq       = irq_ok_q || irq_err_q;
endmodule

// File: rtl/txdesc_engine_chk.sv
module txdesc_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_last,
  input logic       tx_abort,
  input logic       irq
);
  AST_LAST_HAS_BYTE: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);                                   // R5
  AST_CHECK_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> (tx_data == 8'h00));                         // R5
  AST_LAST_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tx_last |=> !tx_last);                                   // R5
  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> irq);                                        // R8
  AST_ABORT_NO_BYTE: assert property (@(posedge clk) disable iff (rst)
    tx_abort |-> (irq && !tx_valid && !tx_last));            // R9
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_abort |=> !tx_abort);                                 // R9
endmodule

bind txdesc_engine txdesc_engine_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tx_valid (tx_valid),
  .tx_data  (tx_data),
  .tx_last  (tx_last),
  .tx_abort (tx_abort),
  .irq      (irq)
);

// File: tb/txdesc_engine_tb.sv
`timescale 1ns/1ps
module txdesc_engine_tb;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          reg_wr;
  logic [7:0]    reg_waddr;
  logic [31:0]   reg_wdata;
  logic [7:0]    reg_raddr;
  logic [31:0]   reg_rdata;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_gnt = 1'b1;
  logic [7:0]    mem_rdata = 8'h00;
  logic          tx_valid, tx_last, tx_abort, irq;
  logic [7:0]    tx_data;

  always #2 clk = ~clk;

  txdesc_engine #(.ADDR_W(AW), .FIFO_DEPTH(64), .N_SLOTS(4)) u_dut (.*);

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  int gnt_mode = 0, gnt_base = 0;
  int grant_cnt = 0, tot = 0, n_last = 0, n_abort = 0, n_req = 0, last_idx = 0;
  logic [7:0] bytes [4096];
  int         gat   [4096];

  // memory model: registered lookup, one cycle after a grant
  always @(posedge clk) begin
    if (mem_req && mem_gnt) begin
      mem_rdata <= mem_addr[7:0] ^ 8'hC3;
      grant_cnt <= grant_cnt + 1;
    end
  end

  always @(negedge clk) begin
    case (gnt_mode)
      0:       mem_gnt = 1'b1;
      1:       mem_gnt = ~mem_gnt;
      default: mem_gnt = ((grant_cnt - gnt_base) < 10);
    endcase
  end

  // output monitor
  always @(negedge clk) begin
    if (mem_req) n_req = n_req + 1;
    if (tx_valid) begin
      bytes[tot] = tx_data;
      gat[tot]   = grant_cnt;
      if (tx_last) begin
        last_idx = tot;
        n_last   = n_last + 1;
      end
      tot = tot + 1;
    end
    if (tx_abort) n_abort = n_abort + 1;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_raddr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_end();
    int nl = n_last, na = n_abort, t = 0;
    while (n_last == nl && n_abort == na && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_frame(input string tag, input int base, input int len, input int s);
    int bad = 0;
    chk({tag, " byte count"}, tot - s, len + 4);
    for (int i = 0; i < len; i++)
      if (bytes[s+i] !== (8'(base + i) ^ 8'hC3)) bad++;
    chk({tag, " payload mismatches"}, bad, 0);
    bad = 0;
    for (int i = 0; i < 4; i++)
      if (bytes[s+len+i] !== 8'h00) bad++;
    chk({tag, " appended bytes nonzero"}, bad, 0);
    chk({tag, " last position"}, last_idx, s + len + 3);
  endtask

  initial begin
    logic [31:0] d;
    int s, g, nr, nl, na;
    bit own_early;
    reg_wr = 1'b0; reg_waddr = '0; reg_wdata = '0; reg_raddr = '0;
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 outputs idle", {tx_valid, tx_last, tx_abort, mem_req, irq}, 0);
    for (int k = 0; k < 4; k++) begin
      rd(8'(8'h10 + 4*k), d); chk("R1 status reset", d, 32'h0000_2000);
      rd(8'(8'h20 + 4*k), d); chk("R1 address reset", d, 0);
    end
    rd(8'h3C, d); chk("R1 irq reg reset", d, 0);

    // R3: writes to a slot that is not current are ignored
    nr = n_req; s = tot;
    wr(8'h24, 32'h0000_5555);
    wr(8'h14, 32'h0000_0020);
    repeat (20) @(negedge clk);
    chk("R3 no fetch from wrong slot", n_req - nr, 0);
    chk("R3 no output from wrong slot", tot - s, 0);
    rd(8'h14, d); chk("R3 wrong slot status unchanged", d, 32'h0000_2000);
    rd(8'h24, d); chk("R3 wrong slot address unchanged", d, 0);

    // slot 0: 60 byte frame, threshold 0 (R2, R4, R5, R7, R8)
    s = tot; nl = n_last;
    wr(8'h20, 32'h0000_0100);
    wr(8'h10, 32'h0000_003C);
    rd(8'h10, d); chk("R2 own cleared after start", d, 32'h0000_003C);
    own_early = 1'b0;
    while (n_last == nl) begin
      @(negedge clk);
      if (n_last == nl && reg_rdata[13]) own_early = 1'b1;
    end
    chk("R7 own returns before frame end", own_early, 1);
    repeat (3) @(negedge clk);
    check_frame("R4 R5 slot0 len60", 32'h100, 60, s);
    rd(8'h10, d); chk("R8 slot0 final status", d, 32'h0000_A03C);
    rd(8'h3C, d); chk("R8 irq ok flag", d, 32'h4);
    chk("R8 irq output", irq, 1);

    // R11: clear semantics
    wr(8'h3C, 32'h0);
    rd(8'h3C, d); chk("R11 zero write keeps flag", d, 32'h4);
    wr(8'h3C, 32'h4);
    rd(8'h3C, d); chk("R11 one clears flag", d, 0);
    chk("R11 irq output low", irq, 0);

    // slot 1: short frame, mid-frame rewrite ignored (R3, R5)
    s = tot;
    wr(8'h24, 32'h0000_0200);
    wr(8'h14, 32'h0000_000A);
    repeat (2) @(negedge clk);
    wr(8'h14, 32'h0000_0032);
    wait_end();
    check_frame("R5 R3 slot1 len10 unpadded", 32'h200, 10, s);
    rd(8'h14, d); chk("R3 busy rewrite ignored", d, 32'h0000_A00A);

    // slot 2: threshold of 32 bytes (R6)
    s = tot; g = grant_cnt;
    wr(8'h28, 32'h0000_0300);
    wr(8'h18, 32'h0001_0064);
    wait_end();
    check_frame("R6 slot2 thr1", 32'h300, 100, s);
    chk("R6 waited for 32 buffered", (gat[s] - g) >= 32, 1);
    rd(8'h18, d); chk("R6 slot2 status", d, 32'h0001_A064);

    // slot 3: threshold above length, stalling grants (R6)
    s = tot; g = grant_cnt;
    gnt_mode = 1;
    wr(8'h2C, 32'h0000_0380);
    wr(8'h1C, 32'h0002_001E);
    wait_end();
    gnt_mode = 0;
    check_frame("R6 slot3 whole frame first", 32'h380, 30, s);
    chk("R6 start only after full fetch", gat[s] - g, 30);

    // R10: rotation back to slot 0; slot 1 is not current
    nr = n_req;
    wr(8'h14, 32'h0000_0010);
    repeat (10) @(negedge clk);
    chk("R10 slot1 not current after slot3", n_req - nr, 0);
    s = tot; g = grant_cnt;
    wr(8'h20, 32'h0000_0400);
    wr(8'h10, 32'h80FF_E0C8);
    rd(8'h10, d); chk("R2 write masking", d, 32'h003F_00C8);
    wait_end();
    check_frame("R10 R6 slot0 wrap fifo-full start", 32'h400, 200, s);
    rd(8'h10, d); chk("R10 slot0 second status", d, 32'h003F_A0C8);

    // slot 1: underrun (R9)
    wr(8'h3C, 32'hC);
    s = tot; nl = n_last; na = n_abort;
    gnt_base = grant_cnt;
    gnt_mode = 2;
    wr(8'h24, 32'h0000_0500);
    wr(8'h14, 32'h0000_0028);
    wait_end();
    gnt_mode = 0;
    chk("R9 abort pulse", n_abort - na, 1);
    chk("R9 no last on abort", n_last - nl, 0);
    chk("R9 frame cut short", (tot - s) < 40, 1);
    rd(8'h14, d); chk("R9 underrun status", d, 32'h4000_6028);
    rd(8'h3C, d); chk("R9 irq error flag", d, 32'h8);

    // slot 2 after abort (R10)
    s = tot;
    wr(8'h28, 32'h0000_0600);
    wr(8'h18, 32'h0000_000C);
    wait_end();
    check_frame("R10 advance after abort", 32'h600, 12, s);
    rd(8'h3C, d); chk("R8 R11 both flags", d, 32'hC);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog all-R act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures + 1);
      $finish;
    end
  end
endmodule